// File: doc/BRIEF.md
# Iterative Integer Divider with Quotient/Remainder Select

This block divides two 64-bit integers over many clock cycles and returns either the quotient or the remainder. A caller presents the operands and three mode bits together with a one-cycle start strobe; the unit drops into a busy phase, produces one quotient bit per cycle with a restoring shift-subtract loop on the operand magnitudes, fixes up the signs and raises a done strobe alongside the registered result.

Two operand situations are settled in a single cycle: a zero divisor, and the signed case of the most negative dividend divided by minus one. Neither traps; each yields a fixed, defined value. A narrow mode works on the low 32 bits of both operands, applies every rule at 32-bit width, and always sign-extends bit 31 of its 32-bit answer into the upper half, including for unsigned operations.

Top module: `intdiv_unit`

## Requirements
- R1: With signed_i=0, rem_sel_i=0 gives the unsigned quotient and rem_sel_i=1 the unsigned remainder of dividend_i by divisor_i (64-bit mode, word_i=0).
- R2: With signed_i=1 the operands are two's complement; the quotient truncates toward zero and a nonzero remainder carries the sign of the dividend.
- R3: A zero divisor gives a quotient of all ones.
- R4: A zero divisor gives a remainder equal to the dividend (in word mode, its low 32 bits sign-extended).
- R5: In signed mode, the most negative dividend divided by all ones (minus one) gives the most negative value as quotient.
- R6: In that same signed overflow case the remainder is zero.
- R7: A zero divisor or a signed overflow completes without iterating: done_o is high in the cycle after the start strobe and busy_o stays low.
- R8: With word_i=1 only bits [31:0] of each operand are used, the zero-divisor and overflow rules apply at 32-bit width (most negative = 0x80000000), and result_o is the 32-bit answer sign-extended from bit 31 for both signed and unsigned operations.
- R9: done_o is high for one cycle per operation, never while busy_o is high, and result_o holds its value until the next completion.
- R10: A start strobe while busy_o is high is ignored: the running operation finishes with its own operands and no extra result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe, accepted only when idle |
| dividend_i | input | 64 | Dividend, sampled with start_i |
| divisor_i | input | 64 | Divisor, sampled with start_i |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| rem_sel_i | input | 1 | 0: return quotient, 1: return remainder |
| word_i | input | 1 | 1: 32-bit operation on bits [31:0], sign-extended result |
| busy_o | output | 1 | High while an iterative division is running |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 64 | Registered result, valid with done_o and held afterwards |

## Verification
The assertions assume operands and mode bits are only meaningful in the cycle where start_i is seen while the unit is idle, and that the partial remainder invariant starts from a cleared state after reset. The stimulus always drives start_i and operands on the falling edge, holds start only one cycle for real requests, and deliberately strobes start with conflicting operands during a busy phase to show that such strobes are dropped. Operand sets cover both signs, both widths, zero divisors and the overflow pair, with upper-half garbage in word mode.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;

  typedef struct packed {
    logic want_rem;
    logic word;
    logic neg_q;
    logic neg_r;
  } div_ctl_t;

endpackage

// File: rtl/intdiv_prep.sv
module intdiv_prep #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            is_signed_i,
  input  logic            word_i,
  output logic [XLEN-1:0] a_ext_o,
  output logic [XLEN-1:0] a_mag_o,
  output logic [XLEN-1:0] b_mag_o,
  output logic            a_neg_o,
  output logic            b_neg_o,
  output logic            zero_div_o,
  output logic            overflow_o
);

  localparam logic [XLEN-1:0] MIN_FULL = {1'b1, {(XLEN-1){1'b0}}};

  logic [XLEN-1:0] a_w, b_w, min_val;

  generate
    if (WLEN < XLEN) begin : g_narrow
      localparam logic [XLEN-1:0] MIN_NARROW = {{(XLEN-WLEN+1){1'b1}}, {(WLEN-1){1'b0}}};
      always_comb begin
        if (word_i) begin
          a_w = is_signed_i ? {{(XLEN-WLEN){a_i[WLEN-1]}}, a_i[WLEN-1:0]}
                            : {{(XLEN-WLEN){1'b0}}, a_i[WLEN-1:0]};
          b_w = is_signed_i ? {{(XLEN-WLEN){b_i[WLEN-1]}}, b_i[WLEN-1:0]}
                            : {{(XLEN-WLEN){1'b0}}, b_i[WLEN-1:0]};
          min_val = MIN_NARROW;
        end else begin
          a_w = a_i;
          b_w = b_i;
          min_val = MIN_FULL;
        end
      end
    end else begin : g_full
      always_comb begin
        a_w = a_i;
        b_w = b_i;
        min_val = MIN_FULL;
      end
    end
  endgenerate

  always_comb begin
    a_neg_o    = is_signed_i & a_w[XLEN-1];
    b_neg_o    = is_signed_i & b_w[XLEN-1];
    a_mag_o    = a_neg_o ? (~a_w + 1'b1) : a_w;
    b_mag_o    = b_neg_o ? (~b_w + 1'b1) : b_w;
    zero_div_o = (b_w == '0);
    overflow_o = is_signed_i & (a_w == min_val) & (&b_w);
    a_ext_o    = a_w;
  end

endmodule

// File: rtl/intdiv_core.sv
module intdiv_core #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [XLEN-1:0] dividend_i,
  input  logic [XLEN-1:0] divisor_i,
  output logic [XLEN-1:0] quo_o,
  output logic [XLEN-1:0] rem_o
);

  logic [XLEN-1:0] q_q, d_q;
  logic [XLEN:0]   r_q;
  logic [XLEN:0]   shifted, diff;
  logic            fits;

  always_comb begin
    shifted = {r_q[XLEN-1:0], q_q[XLEN-1]};
    diff    = shifted - {1'b0, d_q};
    fits    = ~diff[XLEN];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_q <= '0;
      r_q <= '0;
      d_q <= '0;
    end else if (load_i) begin
      q_q <= dividend_i;
      r_q <= '0;
      d_q <= divisor_i;
    end else if (step_i) begin
      r_q <= fits ? diff : shifted;
      q_q <= {q_q[XLEN-2:0], fits};
    end
  end

  assign quo_o = q_q;
  assign rem_o = r_q[XLEN-1:0];

  // R1: the partial remainder of a restoring loop never reaches the divisor
  a_r1_partial_rem_bound: assert property (@(posedge clk) disable iff (rst)
    (d_q != '0) |-> (r_q < {1'b0, d_q}));

endmodule

// File: rtl/intdiv_fix.sv
module intdiv_fix #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] raw_i,
  input  logic            negate_i,
  input  logic            word_i,
  output logic [XLEN-1:0] res_o
);

  logic [XLEN-1:0] v;

  assign v = negate_i ? (~raw_i + 1'b1) : raw_i;

  generate
    if (WLEN < XLEN) begin : g_narrow
      assign res_o = word_i ? {{(XLEN-WLEN){v[WLEN-1]}}, v[WLEN-1:0]} : v;
    end else begin : g_full
      assign res_o = v;
    end
  endgenerate

endmodule

// File: rtl/intdiv_unit.sv
module intdiv_unit
  import intdiv_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [XLEN-1:0] dividend_i,
  input  logic [XLEN-1:0] divisor_i,
  input  logic            signed_i,
  input  logic            rem_sel_i,
  input  logic            word_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] result_o
);

  localparam int CW = $clog2(XLEN);
  localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

  div_state_e      state_q;
  div_ctl_t        ctl_q;
  logic [CW-1:0]   cnt_q;

  logic [XLEN-1:0] a_ext, a_mag, b_mag, quo, rem;
  logic            a_neg, b_neg, zero_div, overflow, special, accept;
  logic [XLEN-1:0] spec_raw, fix_raw, fix_out;
  logic            fix_neg, fix_word;

  intdiv_prep #(.XLEN(XLEN), .WLEN(WLEN)) u_prep (
    .a_i(dividend_i), .b_i(divisor_i), .is_signed_i(signed_i), .word_i(word_i),
    .a_ext_o(a_ext), .a_mag_o(a_mag), .b_mag_o(b_mag),
    .a_neg_o(a_neg), .b_neg_o(b_neg), .zero_div_o(zero_div), .overflow_o(overflow)
  );

  assign accept  = start_i & (state_q == ST_IDLE);
  assign special = zero_div | overflow;

  intdiv_core #(.XLEN(XLEN)) u_core (
    .clk(clk), .rst(rst),
    .load_i(accept & ~special),
    .step_i(state_q == ST_RUN),
    .dividend_i(a_mag), .divisor_i(b_mag),
    .quo_o(quo), .rem_o(rem)
  );

  // zero divisor: q = all ones, r = dividend; overflow: q = dividend (most negative), r = 0
  always_comb begin
    if (rem_sel_i) spec_raw = zero_div ? a_ext : '0;
    else           spec_raw = zero_div ? '1 : a_ext;
  end

  always_comb begin
    if (state_q == ST_IDLE) begin
      fix_raw  = spec_raw;
      fix_neg  = 1'b0;
      fix_word = word_i;
    end else begin
      fix_raw  = ctl_q.want_rem ? rem : quo;
      fix_neg  = ctl_q.want_rem ? ctl_q.neg_r : ctl_q.neg_q;
      fix_word = ctl_q.word;
    end
  end

  intdiv_fix #(.XLEN(XLEN), .WLEN(WLEN)) u_fix (
    .raw_i(fix_raw), .negate_i(fix_neg), .word_i(fix_word), .res_o(fix_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      ctl_q    <= '0;
      cnt_q    <= '0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (special) begin
              result_o <= fix_out;
              done_o   <= 1'b1;
            end else begin
              ctl_q.want_rem <= rem_sel_i;
              ctl_q.word     <= word_i;
              ctl_q.neg_q    <= a_neg ^ b_neg;
              ctl_q.neg_r    <= a_neg;
              cnt_q          <= '0;
              state_q        <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX: begin
          result_o <= fix_out;
          done_o   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  // R7: special operands finish in one cycle without entering the loop
  a_r7_special_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (accept && special) |=> (done_o && !busy_o));

  // R9: completion is never flagged during a busy phase
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R9: the result only moves on a completion
  a_r9_result_held: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_FIX && !accept) |=> $stable(result_o));

  // R10: a strobe during iteration does not end the busy phase
  a_r10_run_keeps_busy: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && start_i) |=> busy_o);

endmodule

// File: tb/intdiv_unit_tb.sv
module intdiv_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_i = 1'b0;
  logic [63:0] dividend_i = '0, divisor_i = '0;
  logic        signed_i = 1'b0, rem_sel_i = 1'b0, word_i = 1'b0;
  logic        busy_o, done_o;
  logic [63:0] result_o;

  int errors = 0;
  int checks = 0;
  int pushes = 0;
  int dones  = 0;
  bit finished = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] held_val;
  bit          hold_chk = 1'b0;

  always #10ns clk = ~clk;

  intdiv_unit u_dut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .signed_i(signed_i), .rem_sel_i(rem_sel_i), .word_i(word_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_div(input logic [63:0] a, input logic [63:0] b,
                                          input bit s, input bit r, input bit w);
    logic [31:0] a32, b32, q32, r32, sel32;
    logic [63:0] q64, r64;
    if (w) begin
      a32 = a[31:0];
      b32 = b[31:0];
      if (b32 == 32'd0) begin q32 = '1; r32 = a32; end
      else if (s && a32 == 32'h8000_0000 && b32 == 32'hFFFF_FFFF) begin q32 = a32; r32 = '0; end
      else if (s) begin q32 = $signed(a32) / $signed(b32); r32 = $signed(a32) % $signed(b32); end
      else begin q32 = a32 / b32; r32 = a32 % b32; end
      sel32 = r ? r32 : q32;
      return {{32{sel32[31]}}, sel32};
    end
    if (b == 64'd0) begin q64 = '1; r64 = a; end
    else if (s && a == 64'h8000_0000_0000_0000 && b == '1) begin q64 = a; r64 = '0; end
    else if (s) begin q64 = $signed(a) / $signed(b); r64 = $signed(a) % $signed(b); end
    else begin q64 = a / b; r64 = a % b; end
    return r ? r64 : q64;
  endfunction

  // driver: called on a falling edge, returns on a falling edge
  task automatic issue(input logic [63:0] a, input logic [63:0] b,
                       input bit s, input bit r, input bit w, input string tag);
    while (busy_o) @(negedge clk);
    dividend_i = a; divisor_i = b; signed_i = s; rem_sel_i = r; word_i = w;
    start_i = 1'b1;
    exp_q.push_back(ref_div(a, b, s, r, w));
    tag_q.push_back(tag);
    pushes++;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic both(input logic [63:0] a, input logic [63:0] b,
                      input bit s, input bit w, input string tag);
    issue(a, b, s, 1'b0, w, {tag, " quotient"});
    issue(a, b, s, 1'b1, w, {tag, " remainder"});
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (done_o) begin
        dones++;
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10: unexpected result actual=%h expected=none", result_o);
        end else begin
          check(result_o, exp_q.pop_front(), tag_q.pop_front());
        end
        held_val = result_o;
        hold_chk = 1'b1;
      end else if (hold_chk) begin
        check(result_o, held_val, "R9 result held after done");
        hold_chk = 1'b0;
      end
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({62'd0, busy_o, done_o}, 64'd0, "reset busy/done");
    check(result_o, 64'd0, "reset result");

    // R1 unsigned 64-bit
    both(64'd100, 64'd7, 1'b0, 1'b0, "R1 100/7");
    both(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 1'b0, 1'b0, "R1 max/3");
    both(64'd5, 64'd9, 1'b0, 1'b0, "R1 small/large");
    both(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, "R1 unsigned no overflow");

    // R2 signed
    both(-64'sd7, 64'sd2, 1'b1, 1'b0, "R2 -7/2");
    both(64'sd7, -64'sd2, 1'b1, 1'b0, "R2 7/-2");
    both(-64'sd7, -64'sd2, 1'b1, 1'b0, "R2 -7/-2");
    both(64'h8000_0000_0000_0000, 64'd3, 1'b1, 1'b0, "R2 min/3");

    // R3 R4 zero divisor
    both(64'h1234_5678_9ABC_DEF0, 64'd0, 1'b0, 1'b0, "R3 R4 unsigned zero divisor");
    both(-64'sd42, 64'd0, 1'b1, 1'b0, "R3 R4 signed zero divisor");

    // R5 R6 overflow
    both(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R5 R6 signed overflow");

    // R8 word mode, upper halves filled with garbage
    both(64'hDEAD_BEEF_FFFF_FFF9, 64'hCAFE_0000_0000_0002, 1'b1, 1'b1, "R8 word signed -7/2");
    both(64'h1111_1111_FFFF_FFF0, 64'h2222_2222_0000_0001, 1'b0, 1'b1, "R8 word unsigned sext");
    both(64'hAAAA_AAAA_8765_4321, 64'h5555_5555_0000_0000, 1'b0, 1'b1, "R8 R4 word zero divisor");
    both(64'h0F0F_0F0F_8000_0000, 64'h0000_0001_FFFF_FFFF, 1'b1, 1'b1, "R8 R5 R6 word overflow");
    both(64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b1, "R8 word unsigned min/max");

    // R7: special case finishes in the very next cycle
    while (busy_o) @(negedge clk);
    issue(64'd99, 64'd0, 1'b0, 1'b0, 1'b0, "R7 fast zero divisor");
    checks++;
    if (!(done_o === 1'b1 && busy_o === 1'b0)) begin
      errors++;
      $display("FAIL R7: actual done=%b busy=%b expected done=1 busy=0", done_o, busy_o);
    end

    // R10: strobes while busy are dropped
    issue(64'd1000, 64'd10, 1'b0, 1'b0, 1'b0, "R10 running op keeps own operands");
    dividend_i = 64'd5; divisor_i = 64'd0; rem_sel_i = 1'b1;
    start_i = 1'b1;
    repeat (3) @(negedge clk);
    start_i = 1'b0;

    while (busy_o || exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(64'(dones), 64'(pushes), "R10 one result per accepted request");
    finish_run();
  end

endmodule